// File: doc/BRIEF.md
# Equalizer Boost Merit Search

This block picks the best receive equalizer boost setting by trying every setting in turn. A start pulse opens a run. The block then presents the boost index it wants measured next. The eye measurement logic sends back a horizontal opening and a vertical opening for that setting over a valid/ready handshake. Each accepted pair is turned into one score. The block keeps the index with the highest score seen so far.

The score rule is chosen by configuration inputs:

- The default rule takes the lesser of the horizontal opening and a scaled vertical opening.
- Two other modes use only the horizontal opening or only the vertical opening.
- A separate enable selects a weighted formula with offsets. This formula takes precedence over the mode field.

When the last setting has been scored, the block raises a one-cycle done pulse. The winning index and its score then stay on the result outputs until the next run finishes.

Top module: `eq_merit_search`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `busy`, `done` and `meas_ready` are 0, and `boost_idx`, `best_idx` and `best_score` are 0.
- R2: A `start` pulse seen while idle makes `busy` and `meas_ready` 1 on the next cycle, with `boost_idx` at 0. Each cycle with `meas_valid` and `meas_ready` both high accepts one measurement. Each accepted measurement before the last one advances `boost_idx` by one.
- R3: With `cfg_custom_en`=0 and `cfg_mode`=2'b00, the score is min(HEO, V). V is (VEO × `cfg_scale`) >> 6, limited to the largest value `EYE_W` bits can hold. `cfg_scale` is unsigned with 6 fraction bits.
- R4: With `cfg_custom_en`=0 and `cfg_mode`=2'b11, the score follows the R3 rule exactly.
- R5: With `cfg_custom_en`=0, `cfg_mode`=2'b01 scores the HEO value alone. `cfg_mode`=2'b10 scores the raw, unscaled VEO value alone.
- R6: With `cfg_custom_en`=1, the score is ((HEO−b)·a + (VEO−c)·(255−a)) >> 8. All arithmetic here is signed. A negative result gives 0. The `cfg_mode` value has no effect in this case.
- R7: The reported index has the largest score among all settings in the run. When scores tie, the lowest index wins.
- R8: The cycle after the last setting (index `N_SET`−1) is accepted, `done` is 1 for exactly one cycle. In that same cycle `busy` is 0, and `best_idx` and `best_score` hold the new result.
- R9: A `start` pulse while `busy` is 1 is ignored, including on the cycle that accepts the last setting. The run continues unchanged and no new run begins.
- R10: `best_idx` and `best_score` change only on the cycle `done` rises. At all other times they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep when idle |
| cfg_mode | input | 2 | Score mode: 00/11 minimum, 01 HEO, 10 VEO |
| cfg_custom_en | input | 1 | Select the weighted formula |
| cfg_a | input | WGT_W | Weight a, where 255 stands for 1.0 |
| cfg_b | input | EYE_W | Offset subtracted from HEO |
| cfg_c | input | EYE_W | Offset subtracted from VEO |
| cfg_scale | input | SCALE_W | VEO scale factor with 6 fraction bits |
| meas_valid | input | 1 | Measurement pair is valid |
| meas_ready | output | 1 | Block accepts a measurement |
| meas_heo | input | EYE_W | Horizontal eye opening |
| meas_veo | input | EYE_W | Vertical eye opening |
| boost_idx | output | IDX_W | Boost setting to be measured now |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| best_idx | output | IDX_W | Winning boost index |
| best_score | output | EYE_W | Score of the winning index |

## Verification
Two events can land in the same cycle. The first pair is a `start` pulse and the acceptance of the last setting. The bench raises `start` together with the final valid measurement. It then requires `done` to pulse, `busy` to stay low one cycle later, and the result to stay unchanged. The second pair is a start during a mid-run stall, which must leave `boost_idx` where it was. Ties are provoked with directed equal peak scores at two indices, and the lower index must be reported.

// File: rtl/eq_merit_pkg.sv
package eq_merit_pkg;
  typedef enum logic [1:0] {
    MERIT_MIN  = 2'b00,
    MERIT_HEO  = 2'b01,
    MERIT_VEO  = 2'b10,
    MERIT_RSVD = 2'b11
  } merit_mode_e;
  localparam int SCALE_FRAC = 6;
endpackage

// File: rtl/merit_calc.sv
module merit_calc
  import eq_merit_pkg::*;
#(
  parameter int EYE_W   = 8,
  parameter int WGT_W   = 8,
  parameter int SCALE_W = 12
) (
  input  logic [1:0]         mode,
  input  logic               custom_en,
  input  logic [WGT_W-1:0]   wa,
  input  logic [EYE_W-1:0]   off_h,
  input  logic [EYE_W-1:0]   off_v,
  input  logic [SCALE_W-1:0] scale,
  input  logic [EYE_W-1:0]   heo,
  input  logic [EYE_W-1:0]   veo,
  output logic [EYE_W-1:0]   score
);
  localparam int MW = EYE_W + SCALE_W;
  localparam int DW = EYE_W + 2;
  localparam int PW = DW + WGT_W + 1;
  localparam int SW = PW + 1;
  localparam logic [EYE_W-1:0] EYE_MAX = {EYE_W{1'b1}};
  localparam logic [WGT_W-1:0] WGT_ONE = {WGT_W{1'b1}};

  logic [MW-1:0]          vmul;
  logic [MW-1:0]          vshr;
  logic [EYE_W-1:0]       vscaled;
  logic [EYE_W-1:0]       mode_score;
  logic signed [DW-1:0]   dh, dv;
  logic signed [WGT_W:0]  wh, wv;
  logic signed [PW-1:0]   ph, pv;
  logic signed [SW-1:0]   wsum, wshr;
  logic [EYE_W-1:0]       custom_score;

  always_comb begin
    vmul = MW'(veo) * MW'(scale);
    vshr = vmul >> SCALE_FRAC;
    if (|vshr[MW-1:EYE_W]) vscaled = EYE_MAX;
    else                   vscaled = vshr[EYE_W-1:0];
  end

  always_comb begin
    unique case (merit_mode_e'(mode))
      MERIT_HEO: mode_score = heo;
      MERIT_VEO: mode_score = veo;
      default:   mode_score = (heo < vscaled) ? heo : vscaled;
    endcase
  end

  always_comb begin
    dh   = $signed({2'b00, heo}) - $signed({2'b00, off_h});
    dv   = $signed({2'b00, veo}) - $signed({2'b00, off_v});
    wh   = $signed({1'b0, wa});
    wv   = $signed({1'b0, WGT_ONE - wa});
    ph   = dh * wh;
    pv   = dv * wv;
    wsum = ph + pv;
    wshr = wsum >>> WGT_W;
    if (wsum[SW-1])                  custom_score = '0;
    else if (|wshr[SW-2:EYE_W])      custom_score = EYE_MAX;
    else                             custom_score = wshr[EYE_W-1:0];
  end

  assign score = custom_en ? custom_score : mode_score;
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl #(
  parameter int N_SET = 16,
  parameter int IDX_W = (N_SET > 1) ? $clog2(N_SET) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             meas_valid,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output logic             accept,
  output logic             first,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SET - 1);

  assign accept = meas_valid & busy;
  assign first  = (idx == '0);
  assign last   = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end else if (accept) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/best_tracker.sv
module best_tracker #(
  parameter int EYE_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             first,
  input  logic             last,
  input  logic [IDX_W-1:0] idx,
  input  logic [EYE_W-1:0] score,
  output logic [IDX_W-1:0] res_idx,
  output logic [EYE_W-1:0] res_score
);
  logic [IDX_W-1:0] run_idx;
  logic [EYE_W-1:0] run_score;
  logic             take;
  logic [IDX_W-1:0] nxt_idx;
  logic [EYE_W-1:0] nxt_score;

  always_comb begin
    take      = first || (score > run_score);
    nxt_idx   = take ? idx   : run_idx;
    nxt_score = take ? score : run_score;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_idx   <= '0;
      run_score <= '0;
      res_idx   <= '0;
      res_score <= '0;
    end else if (accept) begin
      run_idx   <= nxt_idx;
      run_score <= nxt_score;
      if (last) begin
        res_idx   <= nxt_idx;
        res_score <= nxt_score;
      end
    end
  end
endmodule

// File: rtl/eq_merit_search.sv
module eq_merit_search #(
  parameter int N_SET   = 16,
  parameter int EYE_W   = 8,
  parameter int WGT_W   = 8,
  parameter int SCALE_W = 12,
  parameter int IDX_W   = (N_SET > 1) ? $clog2(N_SET) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_custom_en,
  input  logic [WGT_W-1:0]   cfg_a,
  input  logic [EYE_W-1:0]   cfg_b,
  input  logic [EYE_W-1:0]   cfg_c,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic               meas_valid,
  output logic               meas_ready,
  input  logic [EYE_W-1:0]   meas_heo,
  input  logic [EYE_W-1:0]   meas_veo,
  output logic [IDX_W-1:0]   boost_idx,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   best_idx,
  output logic [EYE_W-1:0]   best_score
);
  logic             accept, first, last;
  logic [EYE_W-1:0] score;

  sweep_ctrl #(.N_SET(N_SET), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .meas_valid(meas_valid),
    .busy(busy), .done(done), .idx(boost_idx),
    .accept(accept), .first(first), .last(last)
  );

  assign meas_ready = busy;

  merit_calc #(.EYE_W(EYE_W), .WGT_W(WGT_W), .SCALE_W(SCALE_W)) u_calc (
    .mode(cfg_mode), .custom_en(cfg_custom_en), .wa(cfg_a),
    .off_h(cfg_b), .off_v(cfg_c), .scale(cfg_scale),
    .heo(meas_heo), .veo(meas_veo), .score(score)
  );

  best_tracker #(.EYE_W(EYE_W), .IDX_W(IDX_W)) u_best (
    .clk(clk), .rst(rst), .accept(accept), .first(first), .last(last),
    .idx(boost_idx), .score(score),
    .res_idx(best_idx), .res_score(best_score)
  );
endmodule

// File: rtl/eq_merit_checker.sv
module eq_merit_checker #(
  parameter int N_SET = 16,
  parameter int EYE_W = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             meas_valid,
  input logic             meas_ready,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] boost_idx,
  input logic [IDX_W-1:0] best_idx,
  input logic [EYE_W-1:0] best_score
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SET - 1);
  logic acc;
  assign acc = meas_valid && meas_ready;

  p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && boost_idx != LAST_IDX) |=> (boost_idx == $past(boost_idx) + 1'b1));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && boost_idx == LAST_IDX) |=> (done && !busy));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_busy_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !acc) |=> (busy && $stable(boost_idx)));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(acc && boost_idx == LAST_IDX) |=> ($stable(best_idx) && $stable(best_score)));
endmodule

bind eq_merit_search eq_merit_checker #(.N_SET(N_SET), .EYE_W(EYE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .meas_valid(meas_valid),
  .meas_ready(meas_ready), .busy(busy), .done(done), .boost_idx(boost_idx),
  .best_idx(best_idx), .best_score(best_score)
);

// File: tb/eq_merit_search_bench.sv
module eq_merit_search_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_custom_en = 1'b0;
  logic [7:0]  cfg_a = 8'd0, cfg_b = 8'd0, cfg_c = 8'd0;
  logic [11:0] cfg_scale = 12'd64;
  logic        meas_valid = 1'b0;
  logic        meas_ready;
  logic [7:0]  meas_heo = 8'd0, meas_veo = 8'd0;
  logic [3:0]  boost_idx;
  logic        busy, done;
  logic [3:0]  best_idx;
  logic [7:0]  best_score;

  int checks = 0;
  int errors = 0;
  int heo_v [N];
  int veo_v [N];

  always #4 clk = ~clk;

  eq_merit_search u_eq_merit_search (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode),
    .cfg_custom_en(cfg_custom_en), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .cfg_scale(cfg_scale), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_heo(meas_heo), .meas_veo(meas_veo), .boost_idx(boost_idx),
    .busy(busy), .done(done), .best_idx(best_idx), .best_score(best_score)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_score(int h, int v);
    int sv, s;
    if (cfg_custom_en) begin
      s = (h - int'(cfg_b)) * int'(cfg_a) + (v - int'(cfg_c)) * (255 - int'(cfg_a));
      if (s < 0) return 0;
      s = s >> 8;
      return (s > 255) ? 255 : s;
    end
    sv = (v * int'(cfg_scale)) >> 6;
    if (sv > 255) sv = 255;
    case (cfg_mode)
      2'b01:   return h;
      2'b10:   return v;
      default: return (h < sv) ? h : sv;
    endcase
  endfunction

  task automatic run_sweep(input string req, input bit mid_start, input bit last_start);
    int exp_idx, exp_sc, s;
    logic [3:0] old_idx;
    logic [7:0] old_sc;
    exp_idx = 0;
    exp_sc  = model_score(heo_v[0], veo_v[0]);
    for (int k = 1; k < N; k++) begin
      s = model_score(heo_v[k], veo_v[k]);
      if (s > exp_sc) begin exp_sc = s; exp_idx = k; end
    end
    old_idx = best_idx;
    old_sc  = best_score;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && meas_ready === 1'b1, "R2 busy after start", int'(busy), 1);
    for (int k = 0; k < N; k++) begin
      if (($urandom % 4) == 0) begin
        meas_valid = 1'b0;
        @(negedge clk);
      end
      if (mid_start && k == 5) begin
        start = 1'b1;
        meas_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && boost_idx === 4'd5, "R9 start mid-run ignored", int'(boost_idx), 5);
      end
      chk(boost_idx === 4'(k), "R2 boost index", int'(boost_idx), k);
      chk(best_idx === old_idx && best_score === old_sc, "R10 result held during run",
          int'(best_score), int'(old_sc));
      meas_valid = 1'b1;
      meas_heo = 8'(heo_v[k]);
      meas_veo = 8'(veo_v[k]);
      if (last_start && k == N - 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    meas_valid = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R8 done after last", int'(done), 1);
    chk(best_idx === 4'(exp_idx), {req, " best index"}, int'(best_idx), exp_idx);
    chk(best_score === 8'(exp_sc), {req, " best score"}, int'(best_score), exp_sc);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
    chk(busy === 1'b0, "R9 start at last accept ignored", int'(busy), 0);
    @(negedge clk);
    chk(best_idx === 4'(exp_idx) && best_score === 8'(exp_sc), "R10 result held after run",
        int'(best_score), exp_sc);
  endtask

  task automatic fill_random();
    for (int k = 0; k < N; k++) begin
      heo_v[k] = int'($urandom % 256);
      veo_v[k] = int'($urandom % 256);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && meas_ready === 1'b0, "R1 reset controls", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(boost_idx === 4'd0 && best_idx === 4'd0 && best_score === 8'd0, "R1 reset values",
        int'(best_score), 0);
    chk(busy === 1'b0 && meas_ready === 1'b0, "R1 idle after reset", int'(busy), 0);

    cfg_mode = 2'b00; cfg_scale = 12'd96;
    fill_random();
    run_sweep("R3 min mode", 1'b0, 1'b0);

    cfg_scale = 12'd40;
    for (int k = 0; k < N; k++) begin heo_v[k] = 200; veo_v[k] = 255 - 10 * k; end
    run_sweep("R3 scaled vertical limit", 1'b1, 1'b1);

    cfg_mode = 2'b11; cfg_scale = 12'd200;
    fill_random();
    run_sweep("R4 reserved mode", 1'b0, 1'b1);

    cfg_mode = 2'b01;
    fill_random();
    run_sweep("R5 horizontal only", 1'b1, 1'b0);

    cfg_mode = 2'b10;
    fill_random();
    run_sweep("R5 vertical only", 1'b0, 1'b0);

    cfg_custom_en = 1'b1; cfg_mode = 2'b01;
    cfg_a = 8'd180; cfg_b = 8'd30; cfg_c = 8'd50;
    fill_random();
    run_sweep("R6 weighted formula", 1'b0, 1'b0);

    cfg_mode = 2'b10; cfg_a = 8'd0; cfg_b = 8'd0; cfg_c = 8'd0;
    fill_random();
    run_sweep("R6 weight zero ignores mode", 1'b0, 1'b0);

    cfg_a = 8'd128; cfg_b = 8'd250; cfg_c = 8'd250;
    for (int k = 0; k < N; k++) begin heo_v[k] = 10 + k; veo_v[k] = 20; end
    heo_v[7] = 255; veo_v[7] = 255;
    run_sweep("R6 negative clamp", 1'b0, 1'b0);

    cfg_custom_en = 1'b0; cfg_mode = 2'b01;
    for (int k = 0; k < N; k++) begin heo_v[k] = int'($urandom % 100); veo_v[k] = 0; end
    heo_v[3] = 222; heo_v[9] = 222; heo_v[15] = 222;
    run_sweep("R7 tie keeps lower index", 1'b1, 1'b1);

    for (int k = 0; k < N; k++) begin heo_v[k] = 50; veo_v[k] = 50; end
    run_sweep("R7 all equal", 1'b0, 1'b0);

    for (int k = 0; k < N; k++) begin heo_v[k] = k; veo_v[k] = 0; end
    heo_v[N-1] = 255;
    run_sweep("R7 best at last index", 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule